// File: doc/BRIEF.md
# Dual-Channel Phase-Frequency Detector with Lock Monitor

This block sits between the divider chains of two frequency synthesizer channels and their charge pumps. For each channel it receives a one-cycle tick from the reference divider and one from the feedback divider, both synchronous to the oscillator clock. It runs a three-state phase-frequency comparison and produces raw up/down pulses together with a pump enable and a drive level. A polarity bit per channel picks which pump level corresponds to a leading reference. A pulse of one cycle on both up and down is kept on every comparison, so that a zero phase error still produces activity and the loop has no dead zone.

Each channel has a lock watcher. It measures the width of each one-sided pump interval in oscillator cycles. The channel drops out of lock as soon as that width reaches an unlock threshold. It only regains lock after a set number of consecutive comparisons whose width stayed at or below a tighter lock threshold. A channel in power save stops driving its pump and counts as locked. On release from power save it discards ticks until it has seen one reference edge and one feedback edge, so that it realigns before comparing. The two lock flags are combined by AND. A 3-bit select routes either the combined flag or one of the four comparison tick streams to a single monitor pin. A pump current select bit per channel is passed straight through.

Top module: `dual_pfd_lock`

## Requirements
- R1: While exactly one of a channel's up/down pulses is high, pump_oe is 1. pump_lvl then equals pol when up is the high one and equals the inverse of pol when down is the high one. When up and down are equal, pump_oe and pump_lvl are both 0.
- R2: An accepted reference tick sets pd_up, and an accepted feedback tick sets pd_dn, from the next cycle on. Each stays set until the other side has also arrived. A repeated tick of the same kind changes nothing, so the range saturates beyond one full cycle of error.
- R3: A cycle with both pd_up and pd_dn high lasts exactly one cycle. After it, each flag takes the value of that cycle's accepted tick. Coincident ticks therefore give a one-cycle pulse on both outputs.
- R4: A channel's lock flag falls in the cycle after its one-sided pump interval has lasted UNLOCK_CNT cycles (default 2), without waiting for the comparison to finish.
- R5: A channel's lock flag rises after CONFIRM (default 3) consecutive completed comparisons whose one-sided width was at most LOCK_CNT cycles (default 1). A wider comparison restarts the count.
- R6: While psave of a channel is 1, its pd_up, pd_dn and pump_oe are 0, its ticks are ignored, and it counts as locked.
- R7: After reset and after psave is released, the channel's lock flag is 0 and its confirmation count is cleared. It ignores ticks until it has seen at least one reference tick and one feedback tick, and accepts ticks only from the cycle after the later of those two.
- R8: lock_all is the AND of the two channel flags. Each channel flag is 1 when that channel is locked or in power save. lock_all is 0 after reset unless both channels are in power save.
- R9: With mon_sel[2]=0, mon_out equals lock_all. With mon_sel[2]=1, mon_sel[1] picks the channel and mon_sel[0] picks the feedback tick (1) or the reference tick (0). The codes are 100 for channel 0 reference, 110 for channel 1 reference, 101 for channel 0 feedback and 111 for channel 1 feedback.
- R10: cp_cur equals cp_cur_sel in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 2 | Reference divider tick per channel |
| fb_tick | input | 2 | Feedback divider tick per channel |
| pol | input | 2 | Pump polarity per channel |
| psave | input | 2 | Power save per channel, active high |
| cp_cur_sel | input | 2 | Pump current select per channel |
| mon_sel | input | 3 | Monitor source select |
| pd_up | output | 2 | Raw up pulse per channel |
| pd_dn | output | 2 | Raw down pulse per channel |
| pump_oe | output | 2 | Pump drive enable; 0 means high impedance |
| pump_lvl | output | 2 | Pump drive level while enabled |
| cp_cur | output | 2 | Pump current select, passed through |
| lock_all | output | 1 | Combined lock flag |
| mon_out | output | 1 | Monitor pin |

## Verification
The assertions check several properties on every cycle. Power save silences the pump on the next cycle, and the both-high pulse never outlives a cycle unless new coincident ticks reload it. Release from power save cannot drive the pump at once. A lock flag only rises after a completed comparison and only falls after a driven interval, and full power save forces the combined flag high. The exact unlock instant, the count of good comparisons needed to relock, the realignment that needs both edges, and the monitor routing depend on tick sequences. Those are shown by the bench scenarios and by its per-cycle reference model.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int unsigned NCH = 2;

  // Saturating increment used by the width and confirmation counters.
  function automatic int unsigned step_sat(input int unsigned v, input int unsigned top);
    return (v >= top) ? top : v + 1;
  endfunction

  // Pump level while exactly one side is pending.
  function automatic logic drive_level(input logic up, input logic pol);
    return up ? pol : ~pol;
  endfunction
endpackage

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic fb_tick,
  input  logic psave,
  output logic up,
  output logic dn
);
  logic up_q, dn_q, wait_r, wait_f;
  logic armed, ref_ok, fb_ok;

  assign armed  = !wait_r && !wait_f;
  assign ref_ok = ref_tick && armed;
  assign fb_ok  = fb_tick && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
      wait_r <= 1'b1;
      wait_f <= 1'b1;
    end else if (psave) begin
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
      wait_r <= 1'b1;
      wait_f <= 1'b1;
    end else begin
      if (ref_tick) wait_r <= 1'b0;
      if (fb_tick)  wait_f <= 1'b0;
      if (up_q && dn_q) begin
        up_q <= ref_ok;
        dn_q <= fb_ok;
      end else begin
        up_q <= up_q | ref_ok;
        dn_q <= dn_q | fb_ok;
      end
    end
  end

  assign up = up_q;
  assign dn = dn_q;
endmodule

// File: rtl/lock_watch.sv
module lock_watch
  import pfd_pkg::*;
#(
  parameter int unsigned UNLOCK_CNT = 2,
  parameter int unsigned LOCK_CNT   = 1,
  parameter int unsigned CONFIRM    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up,
  input  logic dn,
  input  logic psave,
  output logic cmp_done,
  output logic locked
);
  localparam int unsigned ERR_MAX = UNLOCK_CNT;
  localparam int unsigned ERR_W   = $clog2(ERR_MAX + 1);
  localparam int unsigned GOOD_W  = $clog2(CONFIRM + 1);

  logic [ERR_W-1:0]  err_q, err_d;
  logic [GOOD_W-1:0] good_q, good_d;
  logic              lock_q, lock_d, one_side;

  assign one_side = up ^ dn;
  assign cmp_done = up & dn;

  always_comb begin
    err_d  = one_side ? ERR_W'(step_sat(32'(err_q), ERR_MAX)) : '0;
    good_d = good_q;
    lock_d = lock_q;
    if (one_side && (32'(err_q) + 32'd1 >= UNLOCK_CNT)) begin
      lock_d = 1'b0;
      good_d = '0;
    end else if (cmp_done) begin
      if (32'(err_q) <= LOCK_CNT) begin
        good_d = GOOD_W'(step_sat(32'(good_q), CONFIRM));
        if (32'(good_q) + 32'd1 >= CONFIRM) lock_d = 1'b1;
      end else begin
        good_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= '0;
      good_q <= '0;
      lock_q <= 1'b0;
    end else if (psave) begin
      err_q  <= '0;
      good_q <= '0;
      lock_q <= 1'b0;
    end else begin
      err_q  <= err_d;
      good_q <= good_d;
      lock_q <= lock_d;
    end
  end

  assign locked = psave | lock_q;
endmodule

// File: rtl/mon_route.sv
module mon_route (
  input  logic [2:0] sel,
  input  logic       lock_all,
  input  logic [1:0] ref_tick,
  input  logic [1:0] fb_tick,
  output logic       mon
);
  always_comb begin
    if (!sel[2]) mon = lock_all;
    else if (sel[0]) mon = fb_tick[sel[1]];
    else mon = ref_tick[sel[1]];
  end
endmodule

// File: rtl/dual_pfd_lock.sv
module dual_pfd_lock
  import pfd_pkg::*;
#(
  parameter int unsigned UNLOCK_CNT = 2,
  parameter int unsigned LOCK_CNT   = 1,
  parameter int unsigned CONFIRM    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ref_tick,
  input  logic [1:0] fb_tick,
  input  logic [1:0] pol,
  input  logic [1:0] psave,
  input  logic [1:0] cp_cur_sel,
  input  logic [2:0] mon_sel,
  output logic [1:0] pd_up,
  output logic [1:0] pd_dn,
  output logic [1:0] pump_oe,
  output logic [1:0] pump_lvl,
  output logic [1:0] cp_cur,
  output logic       lock_all,
  output logic       mon_out
);
  logic [NCH-1:0] ch_lock;
  logic [NCH-1:0] cmp_done;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pfd_core u_pfd (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_tick (ref_tick[i]),
      .fb_tick  (fb_tick[i]),
      .psave    (psave[i]),
      .up       (pd_up[i]),
      .dn       (pd_dn[i])
    );

    lock_watch #(
      .UNLOCK_CNT (UNLOCK_CNT),
      .LOCK_CNT   (LOCK_CNT),
      .CONFIRM    (CONFIRM)
    ) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .up       (pd_up[i]),
      .dn       (pd_dn[i]),
      .psave    (psave[i]),
      .cmp_done (cmp_done[i]),
      .locked   (ch_lock[i])
    );

    assign pump_oe[i]  = pd_up[i] ^ pd_dn[i];
    assign pump_lvl[i] = pump_oe[i] & drive_level(pd_up[i], pol[i]);
  end

  assign lock_all = &ch_lock;
  assign cp_cur   = cp_cur_sel;

  mon_route u_mon (
    .sel      (mon_sel),
    .lock_all (lock_all),
    .ref_tick (ref_tick),
    .fb_tick  (fb_tick),
    .mon      (mon_out)
  );
endmodule

// File: rtl/pfd_lock_chk.sv
module pfd_lock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ref_tick,
  input logic [1:0] fb_tick,
  input logic [1:0] psave,
  input logic [1:0] pd_up,
  input logic [1:0] pd_dn,
  input logic [1:0] pump_oe,
  input logic       lock_all,
  input logic [1:0] ch_lock,
  input logic [1:0] cmp_done
);
  for (genvar i = 0; i < 2; i++) begin : g_chk
    // R6
    psave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      psave[i] |=> !pump_oe[i]) else $error("psave did not silence pump");

    // R3
    both_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_up[i] && pd_dn[i] && !(ref_tick[i] && fb_tick[i])) |=> !(pd_up[i] && pd_dn[i]))
      else $error("both-high pulse stretched");

    // R7
    release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(psave[i]) |=> !pump_oe[i]) else $error("pump driven right after release");

    // R5
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!psave[i] && $past(!psave[i]) && $rose(ch_lock[i])) |-> $past(cmp_done[i]))
      else $error("lock rose without a completed comparison");

    // R4
    lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!psave[i] && $past(!psave[i]) && $fell(ch_lock[i])) |-> $past(pump_oe[i]))
      else $error("lock fell without a driven interval");
  end

  // R8
  all_save_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&psave) |-> lock_all) else $error("full power save not reported locked");
endmodule

bind dual_pfd_lock pfd_lock_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ref_tick (ref_tick),
  .fb_tick  (fb_tick),
  .psave    (psave),
  .pd_up    (pd_up),
  .pd_dn    (pd_dn),
  .pump_oe  (pump_oe),
  .lock_all (lock_all),
  .ch_lock  (ch_lock),
  .cmp_done (cmp_done)
);

// File: tb/sim_dual_pfd_lock.sv
module sim_dual_pfd_lock;
  localparam int UNL = 2;
  localparam int LCK = 1;
  localparam int CNF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ref_t = '0, fb_t = '0, pol_i = 2'b11, ps_i = 2'b10, cur_i = 2'b01;
  logic [2:0] sel_i = 3'b000;
  logic [1:0] pd_up, pd_dn, pump_oe, pump_lvl, cp_cur;
  logic lock_all, mon_out;

  int checks = 0, failures = 0;
  bit finished = 0;

  int m_up[2], m_dn[2], m_err[2], m_good[2], m_lock[2], m_wr[2], m_wf[2];

  always #10 clk = ~clk;

  dual_pfd_lock u0 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_t), .fb_tick(fb_t), .pol(pol_i),
    .psave(ps_i), .cp_cur_sel(cur_i), .mon_sel(sel_i), .pd_up(pd_up), .pd_dn(pd_dn),
    .pump_oe(pump_oe), .pump_lvl(pump_lvl), .cp_cur(cp_cur), .lock_all(lock_all),
    .mon_out(mon_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update();
    for (int c = 0; c < 2; c++) begin
      if (!rst_n || ps_i[c]) begin
        m_up[c] = 0; m_dn[c] = 0; m_err[c] = 0; m_good[c] = 0; m_lock[c] = 0;
        m_wr[c] = 1; m_wf[c] = 1;
      end else begin
        int acc_r, acc_f, nl, ng, nu, nd;
        bit lone;
        acc_r = (ref_t[c] && m_wr[c] == 0 && m_wf[c] == 0) ? 1 : 0;
        acc_f = (fb_t[c] && m_wr[c] == 0 && m_wf[c] == 0) ? 1 : 0;
        lone = (m_up[c] != m_dn[c]);
        nl = m_lock[c]; ng = m_good[c];
        if (lone && m_err[c] + 1 >= UNL) begin nl = 0; ng = 0; end
        else if (m_up[c] == 1 && m_dn[c] == 1) begin
          if (m_err[c] <= LCK) begin
            ng = m_good[c] + 1;
            if (ng >= CNF) nl = 1;
          end else ng = 0;
        end
        if (m_up[c] == 1 && m_dn[c] == 1) begin nu = acc_r; nd = acc_f; end
        else begin nu = m_up[c] | acc_r; nd = m_dn[c] | acc_f; end
        m_err[c] = lone ? m_err[c] + 1 : 0;
        m_up[c] = nu; m_dn[c] = nd; m_lock[c] = nl; m_good[c] = ng;
        if (ref_t[c]) m_wr[c] = 0;
        if (fb_t[c]) m_wf[c] = 0;
      end
    end
  endtask

  task automatic compare();
    int e_oe, e_lvl, e_all, e_mon, flag[2];
    for (int c = 0; c < 2; c++) begin
      e_oe = (m_up[c] != m_dn[c]) ? 1 : 0;
      e_lvl = e_oe ? (m_up[c] ? int'(pol_i[c]) : 1 - int'(pol_i[c])) : 0;
      flag[c] = (ps_i[c] || m_lock[c] == 1) ? 1 : 0;
      chk(pd_up[c] == m_up[c][0], "R2 pd_up", pd_up[c], m_up[c]);
      chk(pd_dn[c] == m_dn[c][0], "R2 pd_dn", pd_dn[c], m_dn[c]);
      chk(pump_oe[c] == e_oe[0], "R1 pump_oe", pump_oe[c], e_oe);
      chk(pump_lvl[c] == e_lvl[0], "R1 pump_lvl", pump_lvl[c], e_lvl);
    end
    e_all = flag[0] & flag[1];
    chk(lock_all == e_all[0], "R8 lock_all", lock_all, e_all);
    if (!sel_i[2]) e_mon = e_all;
    else e_mon = sel_i[0] ? int'(fb_t[sel_i[1]]) : int'(ref_t[sel_i[1]]);
    chk(mon_out == e_mon[0], "R9 mon_out", mon_out, e_mon);
    chk(cp_cur == cur_i, "R10 cp_cur", cp_cur, cur_i);
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int lfsr;
    repeat (3) step();
    chk(lock_all == 1'b0, "R8 reset lock", lock_all, 0);
    chk(pd_up == 2'b00, "R2 reset up", pd_up, 0);
    rst_n = 1'b1;
    step();
    // realign channel 0 after reset
    ref_t = 2'b01; step(); ref_t = 2'b00;
    chk(pd_up[0] == 1'b0, "R7 ref ignored while realigning", pd_up[0], 0);
    fb_t = 2'b01; step(); fb_t = 2'b00;
    chk(pd_dn[0] == 1'b0, "R7 fb ignored while realigning", pd_dn[0], 0);
    step();
    // three zero-error comparisons
    for (int k = 0; k < 3; k++) begin
      ref_t = 2'b01; fb_t = 2'b01; step(); ref_t = 2'b00; fb_t = 2'b00;
      if (k == 0) begin
        chk(pd_up[0] && pd_dn[0], "R3 coincident pulse", {pd_up[0], pd_dn[0]}, 3);
        chk(pump_oe[0] == 1'b0, "R3 no drive on coincidence", pump_oe[0], 0);
      end
      step();
      if (k == 0) chk(!pd_up[0] && !pd_dn[0], "R3 pulse cleared", {pd_up[0], pd_dn[0]}, 0);
      step();
      if (k == 1) chk(lock_all == 1'b0, "R5 not yet locked", lock_all, 0);
    end
    chk(lock_all == 1'b1, "R5 locked after three", lock_all, 1);
    // wide error: reference leads by several cycles
    ref_t = 2'b01; step();
    chk(pump_oe[0] && pump_lvl[0], "R1 lead drives pol", {pump_oe[0], pump_lvl[0]}, 3);
    step();
    chk(pd_up[0] && !pd_dn[0], "R2 repeat ref keeps state", {pd_up[0], pd_dn[0]}, 2);
    chk(lock_all == 1'b1, "R4 still locked", lock_all, 1);
    ref_t = 2'b00; step();
    chk(lock_all == 1'b0, "R4 unlocked on width", lock_all, 0);
    fb_t = 2'b01; step(); fb_t = 2'b00; step(); step();
    // relock with width-1 errors and inverted polarity
    pol_i = 2'b10;
    for (int k = 0; k < 3; k++) begin
      ref_t = 2'b01; step(); ref_t = 2'b00;
      if (k == 0) chk(pump_oe[0] && !pump_lvl[0], "R1 inverted polarity", {pump_oe[0], pump_lvl[0]}, 2);
      fb_t = 2'b01; step(); fb_t = 2'b00;
      step(); step();
      if (k == 1) chk(lock_all == 1'b0, "R5 relock pending", lock_all, 0);
    end
    chk(lock_all == 1'b1, "R5 relocked", lock_all, 1);
    // power save
    ps_i = 2'b11; step();
    chk(pump_oe[0] == 1'b0 && lock_all, "R6 save quiet and locked", {pump_oe[0], lock_all}, 1);
    ref_t = 2'b01; step(); ref_t = 2'b00;
    chk(pd_up[0] == 1'b0, "R6 tick ignored in save", pd_up[0], 0);
    ps_i = 2'b10; step();
    chk(lock_all == 1'b0, "R7 release clears lock", lock_all, 0);
    ref_t = 2'b01; step(); ref_t = 2'b00;
    chk(pd_up[0] == 1'b0, "R7 first ref consumed", pd_up[0], 0);
    fb_t = 2'b01; step(); fb_t = 2'b00;
    chk(pd_dn[0] == 1'b0, "R7 first fb consumed", pd_dn[0], 0);
    ref_t = 2'b01; fb_t = 2'b01; step(); ref_t = 2'b00; fb_t = 2'b00;
    chk(pd_up[0] && pd_dn[0], "R7 rearmed", {pd_up[0], pd_dn[0]}, 3);
    step();
    // monitor routing
    ps_i = 2'b00;
    sel_i = 3'b110; ref_t = 2'b10; step();
    chk(mon_out == 1'b1, "R9 ch1 ref", mon_out, 1);
    sel_i = 3'b101; ref_t = 2'b00; fb_t = 2'b01; step();
    chk(mon_out == 1'b1, "R9 ch0 fb", mon_out, 1);
    sel_i = 3'b100; step();
    chk(mon_out == 1'b0, "R9 ch0 ref idle", mon_out, 0);
    fb_t = 2'b00; cur_i = 2'b10; step();
    chk(cp_cur == 2'b10, "R10 current select", cp_cur, 2);
    // pseudo-random traffic checked by the model every cycle
    lfsr = 32'h1ACE;
    for (int n = 0; n < 600; n++) begin
      lfsr = (lfsr << 1) ^ (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1);
      lfsr = lfsr & 32'hFFFF;
      ref_t = 2'(lfsr >> 1) & 2'(lfsr >> 3);
      fb_t  = 2'(lfsr >> 5) & 2'(lfsr >> 7);
      sel_i = 3'(lfsr >> 9);
      cur_i = 2'(lfsr >> 4);
      if (n % 97 == 50) ps_i = 2'(lfsr);
      if (n % 131 == 7) pol_i = 2'(lfsr >> 2);
      step();
    end
    finish_run();
  end
endmodule